// File: doc/BRIEF.md
# Programmable System Clock Prescaler

This block slows the effective rate of a synchronous subsystem without touching the clock tree. An 8-bit control register, written over a simple single-cycle write port, holds a divide-enable flag and a 7-bit divide code `d`. While division is active, the block raises a clock-enable strobe for one source cycle out of every `129 - d`. Downstream logic qualifies its registers with that strobe. While division is off, the strobe stays high every cycle, so downstream logic runs at the full source rate.

The code is guarded. It can only be loaded in the same access that switches division on from the off state. A write that clears the enable flag throws away the code bits it carries. A write that keeps the flag set while division is already active leaves the stored code alone. Software can therefore retune the rate at run time only by first switching division off and then switching it back on with a new code. Every change of mode or factor restarts the internal period counter.

Control is a two-state machine:

- **States.** BYPASS means division is off. DIVIDE means division is on.
- **Write classes.** Each register write falls into one of four classes:
  - ARM: enable bit 1, machine in BYPASS. Moves BYPASS to DIVIDE and loads the code.
  - HOLD: enable bit 1, machine in DIVIDE. Stays in DIVIDE and leaves the code unchanged.
  - DISARM: enable bit 0, machine in DIVIDE. Moves DIVIDE to BYPASS and discards the code bits.
  - IGNORE: enable bit 0, machine in BYPASS. Stays in BYPASS with no change.
- **No write.** Without a write, the machine holds its state.

Top module: `sysclk_divider`

## Requirements
- R1: After reset the register reads 0x00 and `tick` is high in every cycle.
- R2: `rd_data` always shows the register: bit 7 is the enable flag (1 = dividing) and bits 6:0 are the stored divide code.
- R3: A write with bit 7 = 1 while the enable flag is 0 sets the flag and stores bits 6:0 of that write as the code; the register then reads back exactly the written byte.
- R4: While dividing with code `d`, `tick` is high for exactly one cycle in every `129 - d` cycles. Counting the cycle right after the enabling write's clock edge as cycle 0, the strobe is high in cycles where (cycle mod (129 - d)) equals 128 - d.
- R5: Code 0x7F divides by 2 and code 0x00 divides by 129.
- R6: A write with bit 7 = 1 while already dividing leaves the stored code and the strobe phase unchanged, whatever bits 6:0 carry.
- R7: A write with bit 7 = 0 while dividing clears the flag, discards bits 6:0 of that write (the old code stays readable), and makes `tick` high from the next cycle on.
- R8: A write with bit 7 = 0 while not dividing changes nothing in the register.
- R9: Re-enabling restarts the period counter, so the first strobe comes a full new period after the enabling write, independent of the earlier phase.
- R10: Without a write the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per access |
| wr_data | input | 8 | Write data: bit 7 enable, bits 6:0 divide code |
| rd_data | output | 8 | Register readback |
| tick | output | 1 | Clock-enable strobe to downstream logic |

## Verification
The checker assumes that `wr_en` and `wr_data` are driven synchronously and are stable across the sampling edge. It also assumes that a write strobe lasts exactly one cycle per intended access, so that each high cycle is a separate write. The bench drives all inputs on the falling edge, holds `wr_en` high for exactly one cycle per access, and leaves `wr_data` undefined never. The strobe-spacing property also relies on the factor never being 1. The code width makes that impossible, and the bench exercises the smallest factor, 2, on purpose.

// File: rtl/prescaler_pkg.sv
package prescaler_pkg;

    // Width of the divide code field; the factor is (2**CODE_W + 1) - code.
    localparam int CODE_W = 7;
    localparam int REG_W  = CODE_W + 1;
    localparam int CNT_W  = CODE_W + 1;

    // Operating mode of the control machine.
    typedef enum logic [0:0] {
        ST_BYPASS = 1'b0,
        ST_DIVIDE = 1'b1
    } psc_state_e;

    // Classification of one register access.
    typedef enum logic [2:0] {
        WR_NONE   = 3'd0,
        WR_ARM    = 3'd1,
        WR_HOLD   = 3'd2,
        WR_DISARM = 3'd3,
        WR_IGNORE = 3'd4
    } psc_wr_kind_e;

endpackage

// File: rtl/psc_write_decode.sv
module psc_write_decode
    import prescaler_pkg::*;
(
    input  logic         wr_en,
    input  logic         wr_enable_bit,
    input  psc_state_e   state,
    output psc_wr_kind_e wr_kind
);

    always_comb begin
        wr_kind = WR_NONE;
        if (wr_en) begin
            unique case (state)
                ST_BYPASS: wr_kind = wr_enable_bit ? WR_ARM  : WR_IGNORE;
                ST_DIVIDE: wr_kind = wr_enable_bit ? WR_HOLD : WR_DISARM;
                default:   wr_kind = WR_NONE;
            endcase
        end
    end

endmodule

// File: rtl/psc_ctrl_fsm.sv
module psc_ctrl_fsm
    import prescaler_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  psc_wr_kind_e  wr_kind,
    input  logic [CW-1:0] wr_code,
    output psc_state_e    state,
    output logic [CW-1:0] code,
    output logic          dividing,
    output logic          restart
);

    psc_state_e    state_q, state_d;
    logic [CW-1:0] code_q,  code_d;

    // Next-state and code-load decisions.
    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        unique case (state_q)
            ST_BYPASS: begin
                if (wr_kind == WR_ARM) begin
                    state_d = ST_DIVIDE;
                    code_d  = wr_code;
                end
            end
            ST_DIVIDE: begin
                if (wr_kind == WR_DISARM) begin
                    state_d = ST_BYPASS;
                end
            end
            default: state_d = ST_BYPASS;
        endcase
    end

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BYPASS;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
        end
    end

    // Output process.
    always_comb begin
        state    = state_q;
        code     = code_q;
        dividing = 1'b0;
        restart  = 1'b0;
        unique case (state_q)
            ST_BYPASS: begin
                dividing = 1'b0;
                restart  = (wr_kind == WR_ARM);
            end
            ST_DIVIDE: begin
                dividing = 1'b1;
                restart  = (wr_kind == WR_DISARM);
            end
            default: begin
                dividing = 1'b0;
                restart  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/psc_period_cnt.sv
module psc_period_cnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dividing,
    input  logic          restart,
    input  logic [CW-1:0] factor,
    output logic          tick
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;
    logic          at_end;

    assign last   = factor - CW'(1);
    assign at_end = (cnt_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || !dividing) begin
            cnt_q <= '0;
        end else if (at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign tick = !dividing || at_end;

endmodule

// File: rtl/sysclk_divider.sv
module sysclk_divider
    import prescaler_pkg::*;
#(
    parameter int CODE_BITS = CODE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CODE_BITS:0]   wr_data,
    output logic [CODE_BITS:0]   rd_data,
    output logic                 tick
);

    localparam int                 CNTW    = CODE_BITS + 1;
    localparam logic [CNTW-1:0]    MAX_FAC = CNTW'((1 << CODE_BITS) + 1);

    psc_wr_kind_e          wr_kind;
    psc_state_e            state;
    logic [CODE_BITS-1:0]  code;
    logic                  dividing;
    logic                  restart;
    logic [CNTW-1:0]       factor;

    psc_write_decode u_dec (
        .wr_en         (wr_en),
        .wr_enable_bit (wr_data[CODE_BITS]),
        .state         (state),
        .wr_kind       (wr_kind)
    );

    psc_ctrl_fsm #(.CW(CODE_BITS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_kind  (wr_kind),
        .wr_code  (wr_data[CODE_BITS-1:0]),
        .state    (state),
        .code     (code),
        .dividing (dividing),
        .restart  (restart)
    );

    assign factor = MAX_FAC - {1'b0, code};

    psc_period_cnt #(.CW(CNTW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .dividing (dividing),
        .restart  (restart),
        .factor   (factor),
        .tick     (tick)
    );

    assign rd_data = {dividing, code};

endmodule

// File: rtl/sysclk_divider_chk.sv
module sysclk_divider_chk #(
    parameter int CODE_BITS = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [CODE_BITS:0] wr_data,
    input logic [CODE_BITS:0] rd_data,
    input logic               tick
);

    logic arm_wr, disarm_wr, hold_wr, idle_wr;
    assign arm_wr    = wr_en &&  wr_data[CODE_BITS] && !rd_data[CODE_BITS];
    assign hold_wr   = wr_en &&  wr_data[CODE_BITS] &&  rd_data[CODE_BITS];
    assign disarm_wr = wr_en && !wr_data[CODE_BITS] &&  rd_data[CODE_BITS];
    assign idle_wr   = wr_en && !wr_data[CODE_BITS] && !rd_data[CODE_BITS];

    assert_bypass_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[CODE_BITS] |-> tick);

    assert_arm_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arm_wr |=> rd_data == $past(wr_data));

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[CODE_BITS] && tick && !disarm_wr |=> !tick);

    assert_hold_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_wr |=> rd_data == $past(rd_data));

    assert_disarm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        disarm_wr |=> tick && !rd_data[CODE_BITS] &&
                      rd_data[CODE_BITS-1:0] == $past(rd_data[CODE_BITS-1:0]));

    assert_idle_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        idle_wr |=> $stable(rd_data));

    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        arm_wr |=> !tick);

    assert_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));

endmodule

bind sysclk_divider sysclk_divider_chk #(.CODE_BITS(CODE_BITS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .tick    (tick)
);

// File: tb/sysclk_divider_bench.sv
`timescale 1ns/1ps
module sysclk_divider_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       tick;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    sysclk_divider u_sysclk_divider (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .tick    (tick)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the write edge.
    task automatic do_write(input logic [7:0] data);
        wr_en   = 1'b1;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = 8'h00;
    endtask

    // Samples n cycles starting at cycle 0; counts deviations from the period.
    task automatic count_mismatch(input int n, input int per, input int phase0,
                                  output int bad);
        bad = 0;
        for (int k = 0; k < n; k++) begin
            if (tick !== (((k + phase0) % per) == per - 1)) bad++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset readback", rd_data, 8'h00);
        for (int k = 0; k < 3; k++) begin
            check("R1 strobe high after reset", tick, 1);
            @(negedge clk);
        end
    endtask

    task automatic t_arm_fastest;
        int bad;
        do_write(8'hFF);
        check("R3 readback after arm 0xFF", rd_data, 8'hFF);
        check("R2 enable flag bit 7", rd_data[7], 1);
        count_mismatch(12, 2, 0, bad);
        check("R5 divide by 2 pattern", bad, 0);
        do_write(8'h00);
    endtask

    task automatic t_arm_slowest;
        int bad;
        do_write(8'h80);
        check("R3 readback after arm 0x80", rd_data, 8'h80);
        count_mismatch(300, 129, 0, bad);
        check("R5 divide by 129 pattern", bad, 0);
        do_write(8'h00);
    endtask

    task automatic t_mid_factor;
        int bad;
        do_write(8'hF3);               // d = 0x73 -> factor 14
        count_mismatch(50, 14, 0, bad);
        check("R4 divide by 14 pattern", bad, 0);
        do_write(8'h00);
    endtask

    task automatic t_hold;
        int bad;
        bad = 0;
        do_write(8'hFC);               // d = 124 -> factor 5
        for (int k = 0; k < 20; k++) begin
            if (tick !== ((k % 5) == 4)) bad++;
            if (k == 7) begin
                wr_en   = 1'b1;
                wr_data = 8'h85;
            end else begin
                wr_en   = 1'b0;
                wr_data = 8'h00;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
        check("R6 phase kept across hold write", bad, 0);
        check("R6 code kept across hold write", rd_data, 8'hFC);
    endtask

    task automatic t_disarm_rearm;
        int bad;
        // Still dividing by 5 from t_hold, at an arbitrary phase.
        do_write(8'h33);
        check("R7 flag cleared, code kept", rd_data, 8'h7C);
        check("R7 strobe high after disarm", tick, 1);
        @(negedge clk);
        check("R7 strobe stays high", tick, 1);
        do_write(8'h15);
        check("R8 idle write no change", rd_data, 8'h7C);
        check("R8 strobe still high", tick, 1);
        repeat (3) @(negedge clk);
        check("R10 register held", rd_data, 8'h7C);
        do_write(8'hFE);               // d = 126 -> factor 3
        check("R3 new code loaded", rd_data, 8'hFE);
        count_mismatch(15, 3, 0, bad);
        check("R9 restart full new period", bad, 0);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_arm_fastest();
        t_arm_slowest();
        t_mid_factor();
        t_hold();
        t_disarm_rearm();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule